// File: doc/BRIEF.md
# I2C Register-File Target

This block is an I2C target that lets a bus host read and write a 64-location byte register space (time-keeping registers, a control register and general RAM) held outside the block. SCL and SDA arrive already synchronised to a fast system clock. The block detects bus conditions by oversampling those lines. It pulls SDA low only to acknowledge or to send a zero data bit, so an external open-drain pad and a pull-up finish the bus.

A write transfer carries the target address, then a byte that loads the word pointer, then any number of data bytes. The block writes each data byte through a single-cycle write strobe at the pointer, and the pointer then steps. Reads come in two forms. One form first sets the pointer with a write, then issues a repeated START and the read address. The other form starts reading straight away from wherever the pointer was left. In both, every byte is fetched through a single-cycle read strobe and the pointer steps after each fetch. A power-fail input aborts any transfer, clears the pointer and shuts the block off from the bus while it is held.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The block answers only the 7-bit address 1101000: a first byte of D0h (write) or D1h (read) gets ACK. Any other first byte gets no ACK, causes no register access and no SDA drive, and leaves the pointer unchanged until the next START.
- R2: SDA falling while SCL is high is a START, also when no STOP came before it (repeated START), and restarts address reception. SDA rising while SCL is high is a STOP, after which bytes clocked without a new START are not acknowledged.
- R3: For a byte received by the block, ACK is driven low for the whole 9th clock and released after that clock's falling edge.
- R4: In a write transfer, the byte after the address loads the pointer. Each later byte gives one write strobe with the pointer as address and the byte as data, and the pointer then steps. Bursts have no length limit.
- R5: The pointer is 6 bits wide: a pointer byte of 41h selects location 01h, and stepping past 3Fh gives 00h.
- R6: A standard read (pointer write, repeated START, D1h) returns the data at the written pointer, MSB first, then successive locations.
- R7: A simplified read (START, D1h) returns data starting at the pointer left by the previous transfer.
- R8: After the host answers a read byte with NACK, the block drives nothing and fetches nothing more until a STOP or START.
- R9: While the power-fail input is high, the block drives nothing, makes no register access and acknowledges nothing. When the input is released, the pointer is 00h.
- R10: Each read byte is fetched by one read strobe while SCL is high in the ACK clock that comes before it. Bit 7 is therefore on SDA before the first rising SCL of that byte, and an N-byte read gives exactly N strobes.
- R11: Outside a power-fail event, the block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_fail | input | 1 | High aborts transfer, clears pointer, masks bus |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| sda_pull_low | output | 1 | 1 = pull SDA low, 0 = release |
| reg_addr | output | 6 | Word pointer, address of the register port |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid in the cycle of reg_rd |

## Verification
The assertions assume that SCL and SDA never change in the same system cycle and that each SCL level lasts several system cycles. They also assume that the register port returns read data combinationally in the strobe cycle, and that the host never drives a bus condition while the block is pulling SDA low. The bench keeps within these limits by moving its two lines one at a time, each held for ten system cycles. Its memory model answers the read strobe in the same cycle. It issues STOP or START only after the block has released SDA: after a write ACK, or after a NACK.

// File: rtl/i2c_rf_pkg.sv
`timescale 1ns/1ps
package i2c_rf_pkg;

   localparam logic [6:0] DEF_DEV_ADDR = 7'b1101000;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ADDR,
      ST_PTR,
      ST_ACK_PTR,
      ST_WDATA,
      ST_ACK_WDATA,
      ST_RDATA,
      ST_RACK,
      ST_WAIT_STOP
   } eng_state_t;

endpackage

// File: rtl/i2c_bus_cond.sv
`timescale 1ns/1ps
module i2c_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;
   assign start_det = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/i2c_word_ptr.sv
`timescale 1ns/1ps
module i2c_word_ptr #(
   parameter int PTR_W  = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic              inc,
   input  logic [DATA_W-1:0] load_byte,
   output logic [PTR_W-1:0]  ptr
);
   logic [PTR_W-1:0] load_val;

   generate
      if (PTR_W < DATA_W) begin : g_trunc
         assign load_val = load_byte[PTR_W-1:0];
      end else begin : g_full
         assign load_val = PTR_W'(load_byte);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) ptr <= '0;
      else if (load)     ptr <= load_val;
      else if (inc)      ptr <= ptr + 1'b1;
   end

endmodule

// File: rtl/i2c_rf_engine.sv
`timescale 1ns/1ps
module i2c_rf_engine
   import i2c_rf_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR,
   parameter int         DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_fail,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              sda_low,
   output logic              ptr_clr,
   output logic              ptr_load,
   output logic              ptr_inc,
   output logic [DATA_W-1:0] rx_byte,
   output logic              reg_rd,
   output logic              reg_wr
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   eng_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg, txbuf;
   logic              rw, go_on;
   logic              byte_end;

   assign byte_end = scl_fall && (cnt == CNT_FULL);
   assign rx_byte  = shreg;

   assign reg_wr   = !pwr_fail && state == ST_WDATA && byte_end;
   assign ptr_load = !pwr_fail && state == ST_PTR && byte_end;
   assign reg_rd   = !pwr_fail && scl_rise &&
                     ((state == ST_ACK_ADDR && rw) || (state == ST_RACK && !sda_i));
   assign ptr_inc  = reg_wr | reg_rd;
   assign ptr_clr  = pwr_fail;

   always_comb begin
      case (state)
         ST_ACK_ADDR, ST_ACK_PTR, ST_ACK_WDATA: sda_low = 1'b1;
         ST_RDATA:                             sda_low = ~txbuf[DATA_W-1];
         default:                              sda_low = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || pwr_fail) begin
         state <= ST_IDLE;
         cnt   <= '0;
         shreg <= '0;
         txbuf <= '0;
         rw    <= 1'b0;
         go_on <= 1'b0;
      end else if (start_det) begin
         state <= ST_ADDR;
         cnt   <= '0;
      end else if (stop_det) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_ADDR, ST_PTR, ST_WDATA: begin
               if (scl_rise && cnt != CNT_FULL) begin
                  shreg <= {shreg[DATA_W-2:0], sda_i};
                  cnt   <= cnt + 1'b1;
               end
               if (byte_end) begin
                  cnt <= '0;
                  case (state)
                     ST_ADDR: begin
                        if (shreg[DATA_W-1 -: 7] == DEV_ADDR) begin
                           rw    <= shreg[0];
                           state <= ST_ACK_ADDR;
                        end else begin
                           state <= ST_WAIT_STOP;
                        end
                     end
                     ST_PTR:  state <= ST_ACK_PTR;
                     default: state <= ST_ACK_WDATA;
                  endcase
               end
            end
            ST_ACK_ADDR: begin
               if (scl_rise && rw) txbuf <= reg_rdata;
               if (scl_fall) state <= rw ? ST_RDATA : ST_PTR;
            end
            ST_ACK_PTR, ST_ACK_WDATA: begin
               if (scl_fall) state <= ST_WDATA;
            end
            ST_RDATA: begin
               if (scl_fall) begin
                  if (cnt == CNT_LAST) begin
                     cnt   <= '0;
                     state <= ST_RACK;
                  end else begin
                     cnt   <= cnt + 1'b1;
                     txbuf <= {txbuf[DATA_W-2:0], 1'b0};
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  go_on <= !sda_i;
                  if (!sda_i) txbuf <= reg_rdata;
               end
               if (scl_fall) state <= go_on ? ST_RDATA : ST_WAIT_STOP;
            end
            ST_IDLE, ST_WAIT_STOP: ;
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_low); // R2
   AST_PF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (!sda_low && !reg_wr && !reg_rd)); // R9
   AST_RD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> scl_i); // R10
   AST_WR_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> !scl_i); // R4
   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_low) && !$past(pwr_fail) && !$past(stop_det) && !$past(start_det))
         |-> !scl_i); // R11

endmodule

// File: rtl/i2c_regfile_slave.sv
`timescale 1ns/1ps
module i2c_regfile_slave
   import i2c_rf_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = DEF_DEV_ADDR,
   parameter int         PTR_W    = 6,
   parameter int         DATA_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_fail,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_low,
   output logic [PTR_W-1:0]  reg_addr,
   output logic              reg_wr,
   output logic [DATA_W-1:0] reg_wdata,
   output logic              reg_rd,
   input  logic [DATA_W-1:0] reg_rdata
);
   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("DATA_W must be 8 for byte-oriented transfers");
      end
      if (PTR_W < 1 || PTR_W > DATA_W) begin : g_bad_ptr_w
         $error("PTR_W must lie between 1 and DATA_W");
      end
   endgenerate

   logic scl_rise, scl_fall, start_det, stop_det;
   logic ptr_clr, ptr_load, ptr_inc;
   logic [DATA_W-1:0] rx_byte;

   i2c_bus_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_rf_engine #(.DEV_ADDR(DEV_ADDR), .DATA_W(DATA_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_fail  (pwr_fail),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .reg_rdata (reg_rdata),
      .sda_low   (sda_pull_low),
      .ptr_clr   (ptr_clr),
      .ptr_load  (ptr_load),
      .ptr_inc   (ptr_inc),
      .rx_byte   (rx_byte),
      .reg_rd    (reg_rd),
      .reg_wr    (reg_wr)
   );

   i2c_word_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ptr_clr),
      .load      (ptr_load),
      .inc       (ptr_inc),
      .load_byte (rx_byte),
      .ptr       (reg_addr)
   );

   assign reg_wdata = rx_byte;

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr || reg_rd) && !pwr_fail) |=>
         (pwr_fail || reg_addr == PTR_W'($past(reg_addr) + 1'b1))); // R5
   AST_PF_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> (reg_addr == '0)); // R9
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd)); // R4

endmodule

// File: tb/tb_i2c_regfile_slave.sv
`timescale 1ns/1ps
module tb_i2c_regfile_slave;
   localparam int Q = 10;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n, pwr_fail, host_scl, host_sda;
   logic       sda_pull_low, reg_wr, reg_rd;
   logic [5:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   wire        sda_bus = host_sda & ~sda_pull_low;

   logic [7:0] bank [64];
   logic [7:0] exp_mem [64];
   int exp_ptr, checks, errors, wr_cnt, rd_cnt, drv_viol;
   logic prev_drive, prev_pf;
   bit done;

   i2c_regfile_slave dut (
      .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .scl_i(host_scl), .sda_i(sda_bus),
      .sda_pull_low(sda_pull_low), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
   );

   function automatic logic [7:0] init_val(int i);
      return 8'((i * 37 + 11) ^ 8'h5A);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) for (int i = 0; i < 64; i++) bank[i] <= init_val(i);
      else if (reg_wr) bank[reg_addr] <= reg_wdata;
   end
   assign reg_rdata = bank[reg_addr];

   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr) wr_cnt++;
         if (reg_rd) rd_cnt++;
         if (sda_pull_low != prev_drive && host_scl && !pwr_fail && !prev_pf) drv_viol++;
      end
      prev_drive = sda_pull_low;
      prev_pf    = pwr_fail;
   end

   task automatic qwait;
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic i2c_start;
      host_sda = 1'b1; qwait; host_scl = 1'b1; qwait;
      host_sda = 1'b0; qwait; host_scl = 1'b0; qwait;
   endtask

   task automatic i2c_stop;
      host_sda = 1'b0; qwait; host_scl = 1'b1; qwait; host_sda = 1'b1; qwait;
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         host_sda = b[i]; qwait; host_scl = 1'b1; qwait; qwait; host_scl = 1'b0; qwait;
      end
      host_sda = 1'b1; qwait; host_scl = 1'b1; qwait;
      acked = !sda_bus;
      qwait; host_scl = 1'b0; qwait;
   endtask

   task automatic recv_byte(input bit host_ack, output logic [7:0] d, output logic pre7);
      host_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qwait;
         if (i == 7) pre7 = sda_bus;
         host_scl = 1'b1; qwait; d[i] = sda_bus; qwait; host_scl = 1'b0;
      end
      host_sda = host_ack ? 1'b0 : 1'b1; qwait; host_scl = 1'b1; qwait; qwait;
      host_scl = 1'b0; qwait; host_sda = 1'b1;
   endtask

   task automatic wr_burst(input logic [7:0] pb, input int n);
      bit a; logic [7:0] d; int w0;
      i2c_start;
      send_byte(8'hD0, a); chk(a, "R1 write address ack", a, 1);
      send_byte(pb, a);    chk(a, "R4 pointer byte ack", a, 1);
      chk(sda_pull_low == 1'b0, "R3 ack released after 9th clock", sda_pull_low, 0);
      exp_ptr = pb & 63;
      for (int k = 0; k < n; k++) begin
         d = 8'($urandom); w0 = wr_cnt;
         send_byte(d, a);
         chk(a && wr_cnt == w0 + 1, "R4 data byte acked and written", wr_cnt - w0, 1);
         exp_mem[exp_ptr] = d; exp_ptr = (exp_ptr + 1) % 64;
      end
      i2c_stop;
   endtask

   task automatic rd_body(input int n, input string tag, input int r0);
      logic [7:0] d; logic pre;
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, d, pre);
         chk(d == exp_mem[exp_ptr], tag, d, exp_mem[exp_ptr]);
         chk(pre == d[7], "R10 bit 7 present before first SCL rise", pre, d[7]);
         exp_ptr = (exp_ptr + 1) % 64;
      end
      chk(rd_cnt - r0 == n, "R10 one fetch per read byte", rd_cnt - r0, n);
      qwait; host_scl = 1'b1; qwait;
      chk(sda_bus == 1'b1 && rd_cnt - r0 == n, "R8 quiet after NACK", sda_bus, 1);
      qwait; host_scl = 1'b0; qwait;
      i2c_stop;
   endtask

   task automatic rd_std(input logic [7:0] pb, input int n);
      bit a; int r0;
      i2c_start;
      send_byte(8'hD0, a); chk(a, "R1 write address ack", a, 1);
      send_byte(pb, a);    chk(a, "R6 pointer byte ack", a, 1);
      i2c_start;
      r0 = rd_cnt;
      send_byte(8'hD1, a); chk(a, "R2 repeated start read address ack", a, 1);
      exp_ptr = pb & 63;
      rd_body(n, "R6 standard read data", r0);
   endtask

   task automatic rd_simple(input int n, input string tag);
      bit a; int r0;
      i2c_start;
      r0 = rd_cnt;
      send_byte(8'hD1, a); chk(a, "R1 read address ack", a, 1);
      rd_body(n, tag, r0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      bit a; int w0, r0, mm, kind, n;
      logic [7:0] pb;
      void'($urandom(32'd20240));
      checks = 0; errors = 0; wr_cnt = 0; rd_cnt = 0; drv_viol = 0; done = 0;
      prev_drive = 0; prev_pf = 0;
      rst_n = 1'b0; pwr_fail = 1'b0; host_scl = 1'b1; host_sda = 1'b1;
      for (int i = 0; i < 64; i++) exp_mem[i] = init_val(i);
      exp_ptr = 0;
      repeat (10) @(posedge clk); #1 rst_n = 1'b1; qwait;

      chk(sda_pull_low == 0 && reg_wr == 0 && reg_rd == 0, "R3 idle after reset", sda_pull_low, 0);

      // directed transfers
      wr_burst(8'h05, 3);
      rd_std(8'h05, 3);
      rd_simple(2, "R7 simplified read continues from pointer");
      wr_burst(8'h3E, 4);
      chk(bank[0] == exp_mem[0] && bank[1] == exp_mem[1], "R5 pointer wraps 3F to 00", bank[0], exp_mem[0]);
      rd_std(8'h7E, 4);
      wr_burst(8'h41, 1);
      chk(bank[1] == exp_mem[1], "R5 pointer byte 41h selects 01h", bank[1], exp_mem[1]);

      // wrong addresses: ignored until next START
      i2c_start; w0 = wr_cnt; r0 = rd_cnt;
      send_byte(8'hA0, a); chk(!a, "R1 foreign address not acked", a, 0);
      send_byte(8'h12, a); chk(!a, "R1 ignored after mismatch", a, 0);
      send_byte(8'h34, a);
      chk(!a && wr_cnt == w0 && rd_cnt == r0 && sda_pull_low == 0, "R1 no access after mismatch", wr_cnt - w0, 0);
      i2c_stop;
      i2c_start;
      send_byte(8'hD3, a); chk(!a, "R1 near-miss read address not acked", a, 0);
      i2c_stop;
      rd_simple(1, "R1 pointer unchanged by foreign transfer");

      // bytes after STOP without START
      host_scl = 1'b0; qwait;
      send_byte(8'hD0, a); chk(!a, "R2 no ack without START after STOP", a, 0);
      i2c_stop;

      // power fail in mid write
      i2c_start;
      send_byte(8'hD0, a); send_byte(8'h20, a);
      send_byte(8'h99, a); chk(a, "R4 write before power fail", a, 1);
      exp_mem[8'h20] = 8'h99;
      pwr_fail = 1'b1; qwait; w0 = wr_cnt;
      chk(sda_pull_low == 0, "R9 released on power fail", sda_pull_low, 0);
      send_byte(8'h55, a); chk(!a, "R9 byte ignored during power fail", a, 0);
      i2c_start;
      send_byte(8'hD0, a); chk(!a && wr_cnt == w0, "R9 address ignored during power fail", a, 0);
      pwr_fail = 1'b0; qwait;
      i2c_stop;
      exp_ptr = 0;
      rd_simple(2, "R9 pointer cleared by power fail");

      // constrained random mix
      for (int t = 0; t < 16; t++) begin
         kind = int'($urandom % 3);
         pb   = 8'($urandom);
         n    = 1 + int'($urandom % 5);
         case (kind)
            0: wr_burst(pb, n);
            1: rd_std(pb, n);
            default: rd_simple(n, "R7 random simplified read");
         endcase
      end

      mm = 0;
      for (int i = 0; i < 64; i++) if (bank[i] !== exp_mem[i]) mm++;
      chk(mm == 0, "R4 final register contents", mm, 0);
      chk(drv_viol == 0, "R11 SDA drive changes only with SCL low", drv_viol, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule